// File: doc/BRIEF.md
# Four-Lane Interleaved IQ Phase Corrector

This block takes a stream of complex baseband samples, one 8-bit in-phase and one 8-bit quadrature value per valid cycle. It rotates each sample back to its intended phase using two correction factors, A and B, which arrive alongside the sample. The corrected pair is `I·A − Q·B` and `I·B + Q·A`. Both factors are signed fixed-point numbers with six fraction bits, so the value 64 stands for 1.0. Each result is rounded and then clamped to the 8-bit signed range.

A round-robin distributor hands successive valid samples to four identical lanes. Each lane holds a four-stage complex multiplier: three register stages for the multiply and one for the add, round and clamp. A round-robin collector reads the lanes back in the same lane order. The sample order at the output is therefore the input order, and every result appears a fixed four cycles after its sample. An idle cycle on the input pauses both round-robin pointers. A synchronous reset sends the next sample to the first lane and discards any work still in flight.

Top module: `iq_phase_rotator`

## Requirements
- R1: The in-phase output equals `(I·A − Q·B + 32) >>> 6`, clamped as in R4. All operands are two's complement, and A and B carry 6 fraction bits.
- R2: The quadrature output equals `(I·B + Q·A + 32) >>> 6`, clamped as in R4.
- R3: Rounding adds half an output step before the arithmetic shift. A product sum of +32 gives 1, a sum of −32 gives 0 and a sum of −33 gives −1.
- R4: A rounded result above 127 is output as 127, and one below −128 is output as −128.
- R5: `out_valid` is high in the cycle exactly four clock edges after the edge that sampled `in_valid` high, and at no other time. The result data is presented in that same cycle.
- R6: With `in_valid` held high for many cycles in a row, the results leave in the order the samples arrived.
- R7: Idle cycles inserted between valid samples neither reorder the results nor change their four-cycle delay.
- R8: While `rst` is high, and after it falls, `out_valid` stays low until new samples emerge. Samples accepted before the reset produce no output, and the first sample after the reset is handled normally.
- R9: A and B are captured together with their sample. Changing them on cycles where `in_valid` is low does not alter a result that is already in flight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A sample is present this cycle |
| in_i | input | 8 | In-phase sample, signed |
| in_q | input | 8 | Quadrature sample, signed |
| coef_a | input | 8 | Correction factor A, signed, 6 fraction bits |
| coef_b | input | 8 | Correction factor B, signed, 6 fraction bits |
| out_valid | output | 1 | Corrected result is present this cycle |
| out_i | output | 8 | Corrected in-phase value, signed |
| out_q | output | 8 | Corrected quadrature value, signed |

## Verification
The lane checks rely on the input bringing at most one sample per clock. That guarantees no lane is reloaded before its previous result has been collected, and that only one lane finishes in any cycle. The stimulus honours this by construction, since the driver changes inputs once per cycle and presents a single sample each time. The bench streams back-to-back samples, samples with irregular idle gaps, and a reset that lands while three samples are still in the pipeline. The delay assertions count cycles since reset so that they never look back past it.

// File: rtl/iq_phase_rotator.sv
module iq_phase_rotator #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int FRAC = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  input  logic signed [CW-1:0] coef_a,
  input  logic signed [CW-1:0] coef_b,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_i,
  output logic signed [DW-1:0] out_q
);
  localparam int LANES = 4;
  localparam int LW    = $clog2(LANES);
  localparam int PW    = DW + CW;
  localparam int SW    = PW + 2;
  localparam logic signed [SW-1:0] RND  = SW'(2 ** (FRAC - 1));
  localparam logic signed [SW-1:0] OMAX = SW'(2 ** (DW - 1) - 1);
  localparam logic signed [SW-1:0] OMIN = -OMAX - SW'(1);

  function automatic logic signed [DW-1:0] fix(input logic signed [SW-1:0] s);
    logic signed [SW-1:0] t;
    t = (s + RND) >>> FRAC;
    if (t > OMAX)      fix = OMAX[DW-1:0];
    else if (t < OMIN) fix = OMIN[DW-1:0];
    else               fix = t[DW-1:0];
  endfunction

  logic [LW-1:0]        wr_lane, rd_lane;
  logic [LANES-1:0]     fin_v;
  logic signed [DW-1:0] res_i [LANES];
  logic signed [DW-1:0] res_q [LANES];

  always_ff @(posedge clk) begin
    if (rst)           wr_lane <= '0;
    else if (in_valid) wr_lane <= wr_lane + LW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_lane <= '0;
    else if (out_valid) rd_lane <= rd_lane + LW'(1);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic signed [DW-1:0] si, sq;
    logic signed [CW-1:0] ca, cb;
    logic signed [PW-1:0] p_ia, p_qb, p_ib, p_qa;
    logic signed [PW-1:0] r_ia, r_qb, r_ib, r_qa;
    logic signed [DW-1:0] oi, oq;
    logic [3:0]           v;
    wire take = in_valid && (wr_lane == LW'(k));

    always_ff @(posedge clk) begin
      if (rst) v <= '0;
      else     v <= {v[2:0], take};
    end

    always_ff @(posedge clk) begin
      if (take) begin
        si <= in_i;
        sq <= in_q;
        ca <= coef_a;
        cb <= coef_b;
      end
      p_ia <= si * ca;
      p_qb <= sq * cb;
      p_ib <= si * cb;
      p_qa <= sq * ca;
      r_ia <= p_ia;
      r_qb <= p_qb;
      r_ib <= p_ib;
      r_qa <= p_qa;
      oi   <= fix(SW'(r_ia) - SW'(r_qb));
      oq   <= fix(SW'(r_ib) + SW'(r_qa));
    end

    assign fin_v[k] = v[3];
    assign res_i[k] = oi;
    assign res_q[k] = oq;
  end

  assign out_valid = fin_v[rd_lane];
  assign out_i     = res_i[rd_lane];
  assign out_q     = res_q[rd_lane];

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 4)  since_rst <= since_rst + 3'd1;
  end

  // R5
  lat_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4 && $past(in_valid, 4)) |-> out_valid);

  // R5
  lat_bwd_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 4 && out_valid) |-> $past(in_valid, 4));

  // R6
  one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fin_v));

  // R7
  lane_align_chk: assert property (@(posedge clk) disable iff (rst)
    (|fin_v) |-> fin_v[rd_lane]);

  // R8
  rst_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_lane == '0 && rd_lane == '0 && !out_valid));
endmodule

// File: tb/iq_phase_rotator_tb.sv
module iq_phase_rotator_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [7:0] in_i = '0, in_q = '0, coef_a = '0, coef_b = '0;
  logic out_valid;
  logic signed [7:0] out_i, out_q;

  iq_phase_rotator u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .coef_a(coef_a), .coef_b(coef_b),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  always #10 clk = ~clk;

  localparam int NV = 12;
  // columns: I, Q, A, B; entries 3, 4, 11 saturate (R4); 5 to 8 probe rounding (R3)
  localparam int VI [NV] = '{64, 10, 127, -128, 3,  1, -1, -1, 100, -77, 0,    55};
  localparam int VQ [NV] = '{0,  20, -128, -128, 0, 0,  0,  0, 50,   33,  127,  -9};
  localparam int VA [NV] = '{64, 0,  127, -128, 11, 32, 32, 33, 45,  -60, -128, -3};
  localparam int VB [NV] = '{0,  64, 127, -128, 0,  0,  0,  0,  45,   20,  0,   100};

  int checks = 0, errors = 0;
  int cyc = 0;
  int sent = 0, got = 0;
  int ei [64], eq [64], ec [64];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int x, int y, int a, int b, bit qsel);
    int p, r;
    p = qsel ? (x * b + y * a) : (x * a - y * b);
    r = (p + 32) >>> 6;
    if (r > 127)  r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int x, input int y, input int a, input int b);
    @(negedge clk);
    in_valid = 1'b1;
    in_i = 8'(x); in_q = 8'(y); coef_a = 8'(a); coef_b = 8'(b);
    ei[sent] = model(x, y, a, b, 1'b0);
    eq[sent] = model(x, y, a, b, 1'b1);
    ec[sent] = cyc;
    sent++;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (got >= sent) begin
        chk(1'b0, "R5 R8 unexpected out_valid", 1, 0);
      end else begin
        chk(int'(out_i) == ei[got], "R1 R3 R4 out_i", int'(out_i), ei[got]);
        chk(int'(out_q) == eq[got], "R2 R3 R4 out_q", int'(out_q), eq[got]);
        chk(cyc - ec[got] == 4, "R5 R6 R7 latency", cyc - ec[got], 4);
        got++;
      end
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;

    // R6: back-to-back stream
    for (int k = 0; k < NV; k++) send(VI[k], VQ[k], VA[k], VB[k]);
    idle(8);
    chk(got == sent, "R6 stream count", got, sent);

    // R7: irregular gaps
    for (int k = 0; k < NV; k++) begin
      send(VI[NV-1-k], VQ[NV-1-k], VA[NV-1-k], VB[NV-1-k]);
      if (k % 3 == 0) idle(1);
      if (k % 4 == 1) idle(2);
    end
    idle(8);
    chk(got == sent, "R7 gapped count", got, sent);

    // R9: factors change while sample is in flight
    send(40, -30, 64, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      coef_a = 8'(-100 + k);
      coef_b = 8'(77 - k);
    end
    idle(4);
    chk(got == sent, "R9 held factor count", got, sent);

    // R8: reset while three samples are in flight
    send(20, 20, 64, 64);
    send(-5, 9, 30, -40);
    send(7, 7, 7, 7);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    got = sent;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 out_valid during reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(8);
    chk(got == sent, "R8 flushed count", got, sent);
    send(-90, 45, -64, 32);
    send(33, -33, 16, 48);
    idle(8);
    chk(got == sent, "R8 post-reset count", got, sent);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule